// File: doc/BRIEF.md
# Multiplexed Video Pixel Assembler

This block sits behind a video input port that carries pixels split across several bus samples. It takes bus samples on a 12-bit data input, qualified by a sample-enable strobe, and rebuilds each full pixel from consecutive samples. A format input picks one of five layouts:

- 5-5-5 RGB over two bytes.
- 5-6-5 RGB over two bytes.
- 8-8-8 RGB over three bytes.
- 8-8-8 RGB over two 12-bit words.
- 4:2:2 YCbCr over bytes.

When a pixel is complete, the block raises a one-cycle valid strobe together with three 8-bit colour components.

The source clock, and the capture of data on one or both of its edges, is modelled by the sample-enable input. The clock here only needs to run at least as fast as the sample rate. In YCbCr mode the block also watches the chroma-blue slot for embedded timing reference codes. It turns their field, vertical and horizontal bits into sync flags and keeps those bytes out of the pixel stream. A frame-start pulse, or any change of format, realigns the sample phase.

Top module: `vid_pix_asm`

## Requirements
- R1: Format 0 (5-5-5 RGB): the first byte sample is bits 7:0 and the second is bits 15:8 of a word W, where R=W[14:10], G=W[9:5] and B=W[4:0]. Each 5-bit field is output in the top bits of its component, with the low bits zero. In all byte formats, bus bits 11:8 are ignored.
- R2: Format 1 (5-6-5 RGB): bytes are ordered as in R1, with R=W[15:11], G=W[10:5] and B=W[4:0]. Fields are left-aligned with zero fill.
- R3: Format 2 (8-8-8 RGB over three bytes): the samples arrive as blue, then green, then red. One pixel completes every third sample.
- R4: Format 3 (8-8-8 RGB over 12-bit words): the first word is {G[3:0],B[7:0]} and the second is {R[7:0],G[7:4]}.
- R5: Format 4 (YCbCr): bytes cycle through Cb, Y0, Cr, Y1. Each Y byte produces one pixel strobe. Component 0 carries the latest Cr, component 1 carries Y, and component 2 carries the latest Cb. Before any Cr has arrived since reset, Cr reads 0x80.
- R6: In format 4, the sequence FF 00 00 XY starting in a Cb slot is a timing reference code. None of its bytes produces a pixel. After the XY byte, a one-cycle reference strobe shows sync_f=XY[6], sync_v=XY[5] and sync_h=XY[4], and the next byte is again a Cb slot. The sync flags change only together with that strobe, and the reference strobe never coincides with a pixel strobe.
- R7: In format 4, an FF byte outside the Cb slot is ordinary data. A preamble that breaks (a non-00 byte after FF, or after FF 00) is dropped without output, and the next byte is a Cb slot.
- R8: A cycle with sample-enable low leaves the block unchanged, whatever the bus carries.
- R9: A frame-start pulse returns the phase to the first sample (the Cb slot in format 4). Any sample offered in that same cycle is dropped.
- R10: A change of the format input returns the phase to the first sample. Any sample offered in the cycle of the change is dropped.
- R11: Format codes 5 to 7 are reserved and produce neither pixel nor reference strobes.
- R12: After reset, pixel strobe, reference strobe, components and sync flags are all zero.
- R13: The pixel strobe is high for exactly one cycle. That cycle follows the clock edge that took the pixel's last sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_en | input | 1 | Bus sample is valid this cycle |
| frame_start | input | 1 | Realign sample phase |
| fmt | input | 3 | Format select, codes 0 to 4 (5 to 7 reserved) |
| bus_in | input | 12 | Multiplexed pixel data |
| pix_vld | output | 1 | One-cycle pixel strobe |
| pix_c0 | output | 8 | R, or Cr in YCbCr |
| pix_c1 | output | 8 | G, or Y in YCbCr |
| pix_c2 | output | 8 | B, or Cb in YCbCr |
| trc_vld | output | 1 | One-cycle timing-reference strobe |
| sync_f | output | 1 | Field flag from last reference code |
| sync_v | output | 1 | Vertical blanking flag |
| sync_h | output | 1 | Horizontal flag |

## Verification
Random colour values are pushed through every format with random idle gaps and random bus noise while sample-enable is low. Wrong bit slicing, swapped sample order, wrong zero fill and leakage of idle bus values each show up as a component mismatch. In YCbCr mode, random Cb/Y/Cr/Y quads are mixed with directed reference codes, an FF in a luma slot, and a preamble that breaks after one byte. These separate a decoder that looks in the wrong slot, one that leaks code bytes as pixels, and one that fails to realign. Frame-start and format changes are issued mid-pixel with a sample in the same cycle, and a reserved format is driven with live data. Both show whether the phase counter restarts and whether stray samples are dropped.

// File: rtl/vid_pix_asm.sv
`timescale 1ns/1ps
module vid_pix_asm (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        smp_en,
  input  logic        frame_start,
  input  logic [2:0]  fmt,
  input  logic [11:0] bus_in,
  output logic        pix_vld,
  output logic [7:0]  pix_c0,
  output logic [7:0]  pix_c1,
  output logic [7:0]  pix_c2,
  output logic        trc_vld,
  output logic        sync_f,
  output logic        sync_v,
  output logic        sync_h
);
  localparam logic [2:0] F555 = 3'd0, F565 = 3'd1, F888B = 3'd2, F888W = 3'd3, FYCC = 3'd4;

  logic [2:0]  fmt_q;
  logic [1:0]  ph, tcnt;
  logic [11:0] hold_a;
  logic [7:0]  hold_b, cb_q, cr_q;

  wire        restart = frame_start || (fmt != fmt_q);
  wire        take    = smp_en && !restart;
  wire [7:0]  byte_in = bus_in[7:0];
  wire [15:0] w16     = {byte_in, hold_a[7:0]};
  wire        rgb     = fmt <= F888W;
  wire        last    = (fmt == F888B) ? (ph == 2'd2) : (ph == 2'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmt_q   <= fmt;
      ph      <= '0;
      tcnt    <= '0;
      hold_a  <= '0;
      hold_b  <= '0;
      cb_q    <= 8'h80;
      cr_q    <= 8'h80;
      pix_vld <= 1'b0;
      pix_c0  <= '0;
      pix_c1  <= '0;
      pix_c2  <= '0;
      trc_vld <= 1'b0;
      sync_f  <= 1'b0;
      sync_v  <= 1'b0;
      sync_h  <= 1'b0;
    end else begin
      fmt_q   <= fmt;
      pix_vld <= 1'b0;
      trc_vld <= 1'b0;
      if (restart) begin
        ph   <= '0;
        tcnt <= '0;
      end else if (take && fmt == FYCC) begin
        if (tcnt != 2'd0) begin
          case (tcnt)
            2'd1, 2'd2: tcnt <= (byte_in == 8'h00) ? tcnt + 2'd1 : 2'd0;
            default: begin
              {sync_f, sync_v, sync_h} <= byte_in[6:4];
              trc_vld <= 1'b1;
              tcnt    <= 2'd0;
            end
          endcase
        end else begin
          case (ph)
            2'd0: begin
              if (byte_in == 8'hFF) tcnt <= 2'd1;
              else begin
                cb_q <= byte_in;
                ph   <= 2'd1;
              end
            end
            2'd2: begin
              cr_q <= byte_in;
              ph   <= 2'd3;
            end
            default: begin
              pix_vld <= 1'b1;
              pix_c0  <= cr_q;
              pix_c1  <= byte_in;
              pix_c2  <= cb_q;
              ph      <= ph + 2'd1;
            end
          endcase
        end
      end else if (take && rgb) begin
        if (last) begin
          pix_vld <= 1'b1;
          ph      <= '0;
          case (fmt)
            F555: begin
              pix_c0 <= {w16[14:10], 3'b000};
              pix_c1 <= {w16[9:5],   3'b000};
              pix_c2 <= {w16[4:0],   3'b000};
            end
            F565: begin
              pix_c0 <= {w16[15:11], 3'b000};
              pix_c1 <= {w16[10:5],  2'b00};
              pix_c2 <= {w16[4:0],   3'b000};
            end
            F888B: begin
              pix_c0 <= byte_in;
              pix_c1 <= hold_b;
              pix_c2 <= hold_a[7:0];
            end
            default: begin
              pix_c0 <= bus_in[11:4];
              pix_c1 <= {bus_in[3:0], hold_a[11:8]};
              pix_c2 <= hold_a[7:0];
            end
          endcase
        end else begin
          if (ph == 2'd0) hold_a <= bus_in;
          else            hold_b <= byte_in;
          ph <= ph + 2'd1;
        end
      end
    end
  end

  AST_VLD_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    pix_vld |-> $past(smp_en));                                    // R13
  AST_VLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pix_vld |=> !pix_vld);                                         // R13
  AST_FS_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (!pix_vld && !trc_vld));                       // R9
  AST_SYNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({sync_f, sync_v, sync_h}) |-> trc_vld);               // R6
  AST_TRC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    trc_vld |-> !pix_vld);                                         // R6
  AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt > FYCC) |=> (!pix_vld && !trc_vld));                      // R11
endmodule

// File: tb/vid_pix_asm_test.sv
`timescale 1ns/1ps
module vid_pix_asm_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_en = 1'b0;
  logic frame_start = 1'b0;
  logic [2:0] fmt = 3'd0;
  logic [11:0] bus_in = '0;
  logic pix_vld, trc_vld, sync_f, sync_v, sync_h;
  logic [7:0] pix_c0, pix_c1, pix_c2;

  int checks = 0;
  int errors = 0;
  logic [7:0] last_cr;

  always #4 clk = ~clk;

  vid_pix_asm uut (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .frame_start(frame_start),
    .fmt(fmt), .bus_in(bus_in), .pix_vld(pix_vld), .pix_c0(pix_c0),
    .pix_c1(pix_c1), .pix_c2(pix_c2), .trc_vld(trc_vld),
    .sync_f(sync_f), .sync_v(sync_v), .sync_h(sync_h)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic smp(input logic [11:0] d);
    @(negedge clk);
    bus_in = d;
    smp_en = 1'b1;
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_en = 1'b0;
      bus_in = 12'($urandom);
      @(posedge clk);
      #1;
      chk(!pix_vld && !trc_vld, "R8 idle", {pix_vld, trc_vld}, 0);
    end
  endtask

  task automatic set_fmt(input logic [2:0] f);
    @(negedge clk);
    smp_en = 1'b0;
    fmt = f;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [11:0] noisy(input logic [7:0] b);
    return {4'($urandom), b};
  endfunction

  function automatic logic [7:0] nff();
    return 8'(1 + ($urandom % 254));
  endfunction

  task automatic rgb_pixel(input logic [2:0] f, input logic [7:0] r, input logic [7:0] g, input logic [7:0] b, input string req);
    logic [11:0] s [3];
    logic [7:0] er, eg, eb;
    logic [15:0] w;
    int n;
    n = 2;
    case (f)
      3'd0: begin
        w = {1'b0, r[7:3], g[7:3], b[7:3]};
        s[0] = noisy(w[7:0]); s[1] = noisy(w[15:8]);
        er = {r[7:3], 3'b0}; eg = {g[7:3], 3'b0}; eb = {b[7:3], 3'b0};
      end
      3'd1: begin
        w = {r[7:3], g[7:2], b[7:3]};
        s[0] = noisy(w[7:0]); s[1] = noisy(w[15:8]);
        er = {r[7:3], 3'b0}; eg = {g[7:2], 2'b0}; eb = {b[7:3], 3'b0};
      end
      3'd2: begin
        n = 3;
        s[0] = noisy(b); s[1] = noisy(g); s[2] = noisy(r);
        er = r; eg = g; eb = b;
      end
      default: begin
        s[0] = {g[3:0], b}; s[1] = {r, g[7:4]};
        er = r; eg = g; eb = b;
      end
    endcase
    for (int i = 0; i < n; i++) begin
      smp(s[i]);
      if (i < n - 1) begin
        chk(!pix_vld, {req, " early strobe"}, pix_vld, 0);
        if ($urandom % 3 == 0) idle(1 + $urandom % 2);
      end else begin
        chk(pix_vld && {pix_c0, pix_c1, pix_c2} == {er, eg, eb}, {req, " pixel"},
            {7'd0, pix_vld, pix_c0, pix_c1, pix_c2}, {8'd1, er, eg, eb});
      end
    end
  endtask

  task automatic ycc_quad(input logic [7:0] cb, input logic [7:0] y0, input logic [7:0] cr, input logic [7:0] y1, input string req);
    smp(noisy(cb));
    chk(!pix_vld && !trc_vld, {req, " Cb slot"}, {pix_vld, trc_vld}, 0);
    smp(noisy(y0));
    chk(pix_vld && {pix_c0, pix_c1, pix_c2} == {last_cr, y0, cb}, {req, " Y0"},
        {7'd0, pix_vld, pix_c0, pix_c1, pix_c2}, {8'd1, last_cr, y0, cb});
    smp(noisy(cr));
    chk(!pix_vld, {req, " Cr slot"}, pix_vld, 0);
    last_cr = cr;
    smp(noisy(y1));
    chk(pix_vld && {pix_c0, pix_c1, pix_c2} == {cr, y1, cb}, {req, " Y1"},
        {7'd0, pix_vld, pix_c0, pix_c1, pix_c2}, {8'd1, cr, y1, cb});
  endtask

  task automatic trc(input logic [7:0] xy);
    smp(12'h0FF);
    chk(!pix_vld && !trc_vld, "R6 preamble FF", {pix_vld, trc_vld}, 0);
    smp(12'h000);
    chk(!pix_vld && !trc_vld, "R6 preamble 00", {pix_vld, trc_vld}, 0);
    smp(12'h000);
    chk(!pix_vld && !trc_vld, "R6 preamble 00", {pix_vld, trc_vld}, 0);
    smp({4'h0, xy});
    chk(trc_vld && !pix_vld && {sync_f, sync_v, sync_h} == xy[6:4], "R6 XY decode",
        {trc_vld, pix_vld, sync_f, sync_v, sync_h}, {2'b10, xy[6:4]});
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    last_cr = 8'h80;
    repeat (3) @(posedge clk);
    #1;
    chk(!pix_vld && !trc_vld && {pix_c0, pix_c1, pix_c2} == 0 && {sync_f, sync_v, sync_h} == 0,
        "R12 reset", {pix_vld, trc_vld, pix_c0, pix_c1, pix_c2}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    for (int i = 0; i < 20; i++) rgb_pixel(3'd0, 8'($urandom), 8'($urandom), 8'($urandom), "R1");
    rgb_pixel(3'd0, 8'hFF, 8'h00, 8'hFF, "R1 corner");
    set_fmt(3'd1);
    for (int i = 0; i < 20; i++) rgb_pixel(3'd1, 8'($urandom), 8'($urandom), 8'($urandom), "R2");
    rgb_pixel(3'd1, 8'h00, 8'hFF, 8'h00, "R2 corner");
    set_fmt(3'd2);
    for (int i = 0; i < 20; i++) rgb_pixel(3'd2, 8'($urandom), 8'($urandom), 8'($urandom), "R3");
    set_fmt(3'd3);
    for (int i = 0; i < 20; i++) rgb_pixel(3'd3, 8'($urandom), 8'($urandom), 8'($urandom), "R4");
    rgb_pixel(3'd3, 8'hA5, 8'h3C, 8'h5A, "R4 directed");

    // R10: format change mid-pixel, with a sample in the change cycle
    set_fmt(3'd2);
    smp(12'h011);
    @(negedge clk);
    fmt = 3'd0;
    bus_in = 12'h0EE;
    smp_en = 1'b1;
    @(posedge clk);
    #1;
    chk(!pix_vld, "R10 change cycle", pix_vld, 0);
    rgb_pixel(3'd0, 8'h48, 8'hC8, 8'h30, "R10 realigned");

    // R9: frame start mid-pixel, with a sample in the same cycle
    smp(12'h077);
    @(negedge clk);
    frame_start = 1'b1;
    bus_in = 12'h099;
    smp_en = 1'b1;
    @(posedge clk);
    #1;
    @(negedge clk);
    frame_start = 1'b0;
    smp_en = 1'b0;
    @(posedge clk);
    #1;
    chk(!pix_vld, "R9 frame start cycle", pix_vld, 0);
    rgb_pixel(3'd0, 8'hF8, 8'h08, 8'h80, "R9 realigned");

    set_fmt(3'd4);
    for (int i = 0; i < 20; i++) begin
      ycc_quad(nff(), 8'($urandom), 8'($urandom), 8'($urandom), "R5");
      if ($urandom % 4 == 0) idle(1);
    end

    trc(8'hF0);
    ycc_quad(nff(), 8'h10, 8'h20, 8'h30, "R6 after code");
    chk({sync_f, sync_v, sync_h} == 3'b111, "R6 flags held", {sync_f, sync_v, sync_h}, 3'b111);
    trc(8'hA0);
    ycc_quad(nff(), 8'h44, 8'h55, 8'h66, "R6 after code 2");
    chk({sync_f, sync_v, sync_h} == 3'b010, "R6 flags held 2", {sync_f, sync_v, sync_h}, 3'b010);

    ycc_quad(8'h12, 8'hFF, 8'hFF, 8'hFF, "R7 FF as data");
    smp(12'h0FF);
    chk(!pix_vld && !trc_vld, "R7 broken FF", {pix_vld, trc_vld}, 0);
    smp(12'h012);
    chk(!pix_vld && !trc_vld, "R7 broken byte", {pix_vld, trc_vld}, 0);
    ycc_quad(8'h21, 8'h43, 8'h65, 8'h87, "R7 realigned");
    smp(12'h0FF);
    smp(12'h000);
    smp(12'h034);
    chk(!pix_vld && !trc_vld && {sync_f, sync_v, sync_h} == 3'b010, "R7 broken after 00",
        {pix_vld, trc_vld, sync_f, sync_v, sync_h}, 5'b00010);
    ycc_quad(8'h0A, 8'h0B, 8'h0C, 8'h0D, "R7 realigned 2");

    // R9 in YCbCr: frame start returns to the Cb slot
    smp(12'h033);
    @(negedge clk);
    frame_start = 1'b1;
    smp_en = 1'b0;
    @(posedge clk);
    #1;
    @(negedge clk);
    frame_start = 1'b0;
    ycc_quad(8'h5C, 8'h6D, 8'h7E, 8'h8F, "R9 Cb realign");

    set_fmt(3'd5);
    for (int i = 0; i < 12; i++) begin
      smp(12'($urandom));
      chk(!pix_vld && !trc_vld, "R11 reserved", {pix_vld, trc_vld}, 0);
    end
    set_fmt(3'd7);
    for (int i = 0; i < 4; i++) smp(12'h0FF);
    smp(12'h000);
    chk(!pix_vld && !trc_vld, "R11 reserved 7", {pix_vld, trc_vld}, 0);

    // R8: noisy idle gaps leave a YCbCr pixel intact
    set_fmt(3'd4);
    smp(12'h040);
    idle(3);
    smp(12'h050);
    chk(pix_vld && pix_c1 == 8'h50 && pix_c2 == 8'h40, "R8 gap Y0",
        {pix_vld, pix_c1, pix_c2}, {1'b1, 8'h50, 8'h40});
    idle(1);
    chk(!pix_vld, "R13 one-cycle strobe", pix_vld, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule